// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel data ports, A and B. Each port has its own capture register and its own transfer direction. Each direction has three controls: a clock, a select and an output enable. On every rising edge of its direction's clock, a register stores the bus on its own side. This happens whatever the selects and enables are set to.

The select decides what drives the opposite port: either the live value of the source bus or the stored register contents. The output enables decide whether a port drives or floats. The A-to-B enable is active high and the B-to-A enable is active low.

Each bidirectional bus appears at the boundary as an input, an output and an output-enable. Resolving the bus, including the bus-hold behaviour when both directions drive live data, is left to the surrounding pad or testbench. Output selection and enabling are purely combinational. A synchronous active-low reset clears each register on its own clock.

Top module: `xcvr_top`

## Requirements
- R1: On each rising edge of `clkAb`, the A register loads `aIn`. This happens for every value of `oeAb`, `oeBaN`, `selAb` and `selBa`.
- R2: On each rising edge of `clkBa`, the B register loads `bIn`. The B register is unchanged by edges of `clkAb`.
- R3: `bOe` equals `oeAb` (1 = B port driven, 0 = B port floating), with no clock edge needed.
- R4: `aOe` is 1 when `oeBaN` is 0 and 0 when `oeBaN` is 1, with no clock edge needed.
- R5: With `selAb` = 0, `bOut` follows the live `aIn` combinationally.
- R6: With `selAb` = 1, `bOut` shows the stored A register.
- R7: With `selBa` = 0, `aOut` follows the live `bIn` combinationally.
- R8: With `selBa` = 1, `aOut` shows the stored B register.
- R9: A clock edge with `rstN` = 0 clears that clock's register to all zeros.
- R10: With both enables active and both selects 0, a value placed on one bus is driven back onto it through the other bus. After the outside driver releases, both buses keep that value.
- R11: With both selects 1 and both enables active, both ports drive their stored values at once. Clocking both registers then exchanges their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkAb | input | 1 | Capture clock for the A register |
| clkBa | input | 1 | Capture clock for the B register |
| rstN | input | 1 | Synchronous active-low register clear |
| oeAb | input | 1 | B port drive enable, active high |
| oeBaN | input | 1 | A port drive enable, active low |
| selAb | input | 1 | B port source: 0 live A, 1 stored A |
| selBa | input | 1 | A port source: 0 live B, 1 stored B |
| aIn | input | WIDTH | Value seen on the A bus |
| aOut | output | WIDTH | Data offered to the A bus |
| aOe | output | 1 | A bus driver enable |
| bIn | input | WIDTH | Value seen on the B bus |
| bOut | output | WIDTH | Data offered to the B bus |
| bOe | output | 1 | B bus driver enable |

## Verification
The main sweep uses all 256 byte values. Each value goes on the A bus, with its complement on the B bus, while both ports are isolated. Driving complementary values separates a live path from a stored path, and it shows whether a register picked up the wrong side. Reading each register before and after the other direction's clock shows that each register takes only its own edge.

Two further patterns cover the remaining cases. In the first, the register feeds a driven port while the source bus changes, which shows that capture ignores the output controls. In the second, both ports drive at once, first with live data and then with stored data. Together these show the bus-hold loop and the register exchange.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Lane index 0: A-to-B direction (drives port B)
  // Lane index 1: B-to-A direction (drives port A)
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic [NUM_LANES-1:0] drive;
    logic [NUM_LANES-1:0] useStore;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
`timescale 1ns/1ps
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        oeAb,
  input  logic        oeBaN,
  input  logic        selAb,
  input  logic        selBa,
  output xcvrStrobe_t strobe
);
  // The two enables have opposite polarity; normalise both to active high.
  always_comb begin
    strobe.drive[0]    = oeAb;
    strobe.drive[1]    = ~oeBaN;
    strobe.useStore[0] = selAb;
    strobe.useStore[1] = selBa;
  end
endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] srcBus,
  input  logic             useStore,
  input  logic             drive,
  output logic [WIDTH-1:0] outData,
  output logic             outEn
);
  logic [WIDTH-1:0] stored;

  // Capture is unconditional: neither select nor enable gates it.
  always_ff @(posedge clk) begin
    if (!rstN) stored <= '0;
    else       stored <= srcBus;
  end

  assign outData = useStore ? stored : srcBus;
  assign outEn   = drive;
endmodule

// File: rtl/xcvr_top.sv
`timescale 1ns/1ps
module xcvr_top
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clkAb,
  input  logic             clkBa,
  input  logic             rstN,
  input  logic             oeAb,
  input  logic             oeBaN,
  input  logic             selAb,
  input  logic             selBa,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  xcvrStrobe_t strobe;

  logic [NUM_LANES-1:0] laneClk;
  logic [WIDTH-1:0]     laneSrc [NUM_LANES];
  logic [WIDTH-1:0]     laneOut [NUM_LANES];
  logic [NUM_LANES-1:0] laneOe;

  assign laneClk    = {clkBa, clkAb};
  assign laneSrc[0] = aIn;
  assign laneSrc[1] = bIn;

  xcvr_ctrl u_ctrl (
    .oeAb  (oeAb),
    .oeBaN (oeBaN),
    .selAb (selAb),
    .selBa (selBa),
    .strobe(strobe)
  );

  for (genvar d = 0; d < NUM_LANES; d++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk     (laneClk[d]),
      .rstN    (rstN),
      .srcBus  (laneSrc[d]),
      .useStore(strobe.useStore[d]),
      .drive   (strobe.drive[d]),
      .outData (laneOut[d]),
      .outEn   (laneOe[d])
    );
  end

  assign bOut = laneOut[0];
  assign bOe  = laneOe[0];
  assign aOut = laneOut[1];
  assign aOe  = laneOe[1];
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clkAb,
  input logic             clkBa,
  input logic             rstN,
  input logic             oeAb,
  input logic             oeBaN,
  input logic             selAb,
  input logic             selBa,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOe
);
  a_r3_b_enable: assert property (@(posedge clkAb) disable iff (!rstN)
    oeAb == bOe);

  a_r4_a_enable: assert property (@(posedge clkBa) disable iff (!rstN)
    oeBaN != aOe);

  a_r5_live_a_to_b: assert property (@(posedge clkAb) disable iff (!rstN)
    !selAb |-> bOut == aIn);

  a_r7_live_b_to_a: assert property (@(posedge clkBa) disable iff (!rstN)
    !selBa |-> aOut == bIn);

  // R1 and R6: the stored A value seen now is the A bus of the previous edge
  a_r6_stored_a: assert property (@(posedge clkAb) disable iff (!rstN)
    ($past(rstN) && selAb) |-> bOut == $past(aIn));

  // R2 and R8
  a_r8_stored_b: assert property (@(posedge clkBa) disable iff (!rstN)
    ($past(rstN) && selBa) |-> aOut == $past(bIn));

  a_r9_clear_a: assert property (@(posedge clkAb)
    !rstN |=> (!selAb || bOut == '0));

  a_r9_clear_b: assert property (@(posedge clkBa)
    !rstN |=> (!selBa || aOut == '0));
endmodule

bind xcvr_top xcvr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_xcvr_top.sv
`timescale 1ns/1ps
module sim_xcvr_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clkAb = 1'b0, clkBa = 1'b0, rstN = 1'b0;
  logic oeAb = 1'b0, oeBaN = 1'b1, selAb = 1'b0, selBa = 1'b0;
  logic [W-1:0] aBus = '0, bBus = '0, extA = '0, extB = '0;
  logic extAEn = 1'b0, extBEn = 1'b0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;
  logic [W-1:0] expA = '0, expB = '0;
  int tests = 0, fails = 0, cycles = 0;

  xcvr_top #(.WIDTH(W)) u0 (
    .clkAb(clkAb), .clkBa(clkBa), .rstN(rstN),
    .oeAb(oeAb), .oeBaN(oeBaN), .selAb(selAb), .selBa(selBa),
    .aIn(aBus), .aOut(aOut), .aOe(aOe),
    .bIn(bBus), .bOut(bOut), .bOe(bOe)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Resolve both buses: the outside driver wins, then the block,
  // otherwise the bus keeps its last value.
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      #1;
      aBus = extAEn ? extA : (aOe ? aOut : aBus);
      bBus = extBEn ? extB : (bOe ? bOut : bBus);
    end
    #1;
  endtask

  task automatic pulseAb();
    settle();
    clkAb = 1'b1;
    expA = rstN ? aBus : '0;
    #1 clkAb = 1'b0;
    settle();
  endtask

  task automatic pulseBa();
    settle();
    clkBa = 1'b1;
    expB = rstN ? bBus : '0;
    #1 clkBa = 1'b0;
    settle();
  endtask

  task automatic pulseBoth();
    settle();
    clkAb = 1'b1;
    clkBa = 1'b1;
    expA = rstN ? aBus : '0;
    expB = rstN ? bBus : '0;
    #1;
    clkAb = 1'b0;
    clkBa = 1'b0;
    settle();
  endtask

  initial begin
    // R9: reset clears both registers, seen through the stored paths
    extAEn = 1'b1; extBEn = 1'b1; extA = 8'hC3; extB = 8'h3C;
    selAb = 1'b1; selBa = 1'b1;
    pulseBoth();
    chk("R9 A reg cleared", bOut, 8'h00);
    chk("R9 B reg cleared", aOut, 8'h00);
    rstN = 1'b1;
    settle();

    // R3 R4: all enable combinations, no clock edge
    for (int e = 0; e < 4; e++) begin
      oeAb = e[0];
      oeBaN = e[1];
      settle();
      chk("R3 bOe", {7'b0, bOe}, {7'b0, e[0]});
      chk("R4 aOe", {7'b0, aOe}, {7'b0, ~e[1]});
    end

    // Isolation sweep: R1 R2 R5 R6 R7 R8
    oeAb = 1'b0; oeBaN = 1'b1;
    for (int i = 0; i < 256; i++) begin
      extA = 8'(i);
      extB = ~8'(i);
      selAb = 1'b0; selBa = 1'b0;
      settle();
      chk("R5 live A to B", bOut, 8'(i));
      chk("R7 live B to A", aOut, ~8'(i));
      pulseAb();
      selAb = 1'b1; selBa = 1'b1;
      settle();
      chk("R1 R6 stored A", bOut, 8'(i));
      chk("R2 B unchanged by clkAb", aOut, expB);
      pulseBa();
      chk("R2 R8 stored B", aOut, ~8'(i));
      chk("R1 A unchanged by clkBa", bOut, 8'(i));
    end

    // R1: capture while B is driven from the register
    oeAb = 1'b1; selAb = 1'b1; extBEn = 1'b0;
    extA = 8'h96;
    settle();
    chk("R6 B bus holds stored A", bBus, ~8'hFF ^ 8'hFF);
    pulseAb();
    chk("R1 capture with B driven", bBus, 8'h96);

    // R10: real-time both ways, bus hold after release
    oeAb = 1'b1; oeBaN = 1'b0; selAb = 1'b0; selBa = 1'b0;
    extAEn = 1'b1; extBEn = 1'b0; extA = 8'h5A;
    settle();
    chk("R10 B follows A", bBus, 8'h5A);
    extAEn = 1'b0;
    settle();
    chk("R10 A held", aBus, 8'h5A);
    chk("R10 B held", bBus, 8'h5A);

    // R11: both stored paths drive, then swap registers
    extAEn = 1'b0; extBEn = 1'b0;
    oeAb = 1'b0; oeBaN = 1'b1;
    extAEn = 1'b1; extBEn = 1'b1; extA = 8'h11; extB = 8'hEE;
    pulseBoth();
    extAEn = 1'b0; extBEn = 1'b0;
    selAb = 1'b1; selBa = 1'b1; oeAb = 1'b1; oeBaN = 1'b0;
    settle();
    chk("R11 B bus = stored A", bBus, 8'h11);
    chk("R11 A bus = stored B", aBus, 8'hEE);
    pulseBoth();
    chk("R11 swapped B bus", bBus, 8'hEE);
    chk("R11 swapped A bus", aBus, 8'h11);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule